// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor load/store port and a slower, word-addressed memory. It holds eight single-word lines, organised as four sets of two ways. Each line keeps a valid flag, a dirty flag, a tag and one 32-bit word. A request that finds its word in the cache is answered on the next clock edge without touching memory. A request that misses stalls the processor port. The cache then picks the least recently used way of the indexed set. If that line is dirty it is written back first, and the word is then fetched.

Writes follow a write-back, write-allocate policy. A store that hits changes only the cached copy and marks it dirty. A store that misses first brings the word in and then overwrites it with the store data. A flush request walks every line, copies each dirty line to memory and marks it clean. The lines stay valid after a flush.

Top module: `dcache_wb`

## Requirements
- R1: After reset no line is valid and every dirty flag is clear, so the first access to any address misses. `cpu_req_ready` is 1 and `cpu_resp_valid`, `mem_valid` and `flush_busy` are 0.
- R2: Byte address bits [1:0] are ignored. Bits [3:2] select the set and bits [31:4] form the tag. Addresses that differ only in bits [1:0] reach the same word.
- R3: A request accepted on a hit gets `cpu_resp_valid`=1 with `cpu_resp_hit`=1 in the very next cycle, and no memory operation is issued for it.
- R4: A store that hits updates only the cached word and sets its dirty flag. Memory keeps its old value until that line is evicted or flushed.
- R5: A store that misses first reads the word from memory, then merges the store data into the line and leaves the line dirty. The response carries `cpu_resp_hit`=0. For stores, `cpu_resp_rdata` is the stored word.
- R6: The victim on a miss is the least recently used way of the indexed set. One recency bit per set is updated on every hit and on every fill.
- R7: A dirty victim is written to memory at its own word address before the read for the new word is issued. A clean victim causes no memory write.
- R8: Reads from byte addresses 0, 32, 0, 24, 32, 64 after reset give miss, miss, hit, miss, hit, miss.
- R9: `cpu_req_ready` is 0 from the cycle after a miss is accepted until the miss response is given, and whenever a memory request is outstanding.
- R10: A pulse on `flush_start` while the cache is idle raises `flush_busy`. Every dirty line is then written back in order of ascending set and, within a set, way 0 first, and each one is marked clean. A second flush with no stores in between writes nothing.
- R11: `mem_valid`, `mem_we` and `mem_addr` hold steady until the memory answers with a one-cycle `mem_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | Response strobe, one cycle |
| cpu_resp_hit | output | 1 | Request was served without a fill |
| cpu_resp_rdata | output | 32 | Load data, or the stored word for stores |
| flush_start | input | 1 | Start a write-back walk of all lines |
| flush_busy | output | 1 | Flush walk in progress |
| mem_valid | output | 1 | Memory request outstanding |
| mem_we | output | 1 | 1 = write back, 0 = fill read |
| mem_addr | output | 30 | Word address to memory |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Memory completion pulse |
| mem_rdata | input | 32 | Fill data, valid with `mem_ready` |

## Verification
The checks take for granted that memory raises `mem_ready` only while `mem_valid` is high, for one cycle per request, and never two cycles in a row. They also assume the processor keeps its request fields stable until `cpu_req_ready` accepts them, and that `flush_start` is pulsed only while no miss is in progress. The bench memory model counts a fixed latency from `mem_valid` and then returns a single pulse. The processor tasks hold each request until it is accepted and wait for its response before issuing another. A flush is started only after the previous response has been seen.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int OFS_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_FL_SCAN,
        ST_FL_WB
    } dc_state_e;

    function automatic logic line_needs_wb(input logic vld, input logic drt);
        return vld && drt;
    endfunction

    function automatic logic is_mem_state(input dc_state_e st);
        return (st == ST_WBACK) || (st == ST_FILL) || (st == ST_FL_WB);
    endfunction

endpackage

// File: rtl/dc_store.sv
module dc_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(SETS)-1:0]      rd_set,
    output logic [1:0]                   rd_valid,
    output logic [1:0]                   rd_dirty,
    output logic [TAG_W-1:0]             rd_tag [2],
    output logic [DATA_W-1:0]            rd_data [2],
    output logic                         rd_lru,
    input  logic                         wr_en,
    input  logic [$clog2(SETS)-1:0]      wr_set,
    input  logic                         wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_dirty,
    input  logic                         lru_en,
    input  logic [$clog2(SETS)-1:0]      lru_set,
    input  logic                         lru_used
);
    logic [1:0]        valid_q [SETS];
    logic [1:0]        dirty_q [SETS];
    logic [SETS-1:0]   lru_q;
    logic [TAG_W-1:0]  tag_q   [SETS][2];
    logic [DATA_W-1:0] data_q  [SETS][2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_set][wr_way] <= 1'b1;
                dirty_q[wr_set][wr_way] <= wr_dirty;
            end
            if (lru_en)
                lru_q[lru_set] <= ~lru_used;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_lru   = lru_q[rd_set];

    for (genvar w = 0; w < 2; w++) begin : g_way_rd
        assign rd_tag[w]  = tag_q[rd_set][w];
        assign rd_data[w] = data_q[rd_set][w];
    end
endmodule

// File: rtl/dc_match.sv
module dc_match #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic [1:0]        way_valid,
    input  logic [TAG_W-1:0]  way_tag  [2],
    input  logic [DATA_W-1:0] way_data [2],
    input  logic [TAG_W-1:0]  req_tag,
    output logic              hit,
    output logic              hit_way,
    output logic [DATA_W-1:0] hit_data
);
    logic [1:0] eq;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign eq[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit      = |eq;
    assign hit_way  = eq[1];
    assign hit_data = eq[1] ? way_data[1] : way_data[0];
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req_valid,
    output logic                    cpu_req_ready,
    input  logic                    cpu_req_write,
    input  logic [ADDR_W-1:0]       cpu_req_addr,
    input  logic [DATA_W-1:0]       cpu_req_wdata,
    output logic                    cpu_resp_valid,
    output logic                    cpu_resp_hit,
    output logic [DATA_W-1:0]       cpu_resp_rdata,
    input  logic                    flush_start,
    output logic                    flush_busy,
    output logic                    mem_valid,
    output logic                    mem_we,
    output logic [ADDR_W-OFS_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ready,
    input  logic [DATA_W-1:0]       mem_rdata
);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFS_W - SET_W;
    localparam int LINES  = 2 * SETS;
    localparam int LINE_W = $clog2(LINES);

    dc_state_e         state_q;
    logic              req_we_q;
    logic [SET_W-1:0]  req_set_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              victim_q;
    logic [LINE_W-1:0] fl_idx_q;

    logic [SET_W-1:0]  cpu_set, rd_set, fl_set;
    logic [TAG_W-1:0]  cpu_tag;
    logic              fl_way, fl_last, sel_way, accept;
    logic [1:0]        rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag  [2];
    logic [DATA_W-1:0] rd_data [2];
    logic              rd_lru, hit, hit_way;
    logic [DATA_W-1:0] hit_data, fill_word;
    logic              wr_en, wr_way, wr_dirty, lru_en, lru_used;
    logic [SET_W-1:0]  wr_set, lru_set;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic [OFS_W-1:0]  unused_ofs;

    assign unused_ofs = cpu_req_addr[OFS_W-1:0];
    assign cpu_set    = cpu_req_addr[OFS_W +: SET_W];
    assign cpu_tag    = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign fl_set     = fl_idx_q[LINE_W-1:1];
    assign fl_way     = fl_idx_q[0];
    assign fl_last    = (fl_idx_q == LINE_W'(LINES - 1));

    assign cpu_req_ready = (state_q == ST_IDLE) && !flush_start;
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign flush_busy    = (state_q == ST_FL_SCAN) || (state_q == ST_FL_WB);
    assign mem_valid     = is_mem_state(state_q);
    assign mem_we        = (state_q != ST_FILL);

    always_comb begin
        case (state_q)
            ST_IDLE:               rd_set = cpu_set;
            ST_FL_SCAN, ST_FL_WB:  rd_set = fl_set;
            default:               rd_set = req_set_q;
        endcase
    end

    assign sel_way   = flush_busy ? fl_way : victim_q;
    assign mem_addr  = (state_q == ST_FILL) ? {req_tag_q, req_set_q}
                                            : {rd_tag[sel_way], rd_set};
    assign mem_wdata = rd_data[sel_way];
    assign fill_word = req_we_q ? req_wdata_q : mem_rdata;

    dc_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_set(rd_set), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_data(rd_data), .rd_lru(rd_lru),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_dirty(wr_dirty),
        .lru_en(lru_en), .lru_set(lru_set), .lru_used(lru_used)
    );

    dc_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
        .way_valid(rd_valid), .way_tag(rd_tag), .way_data(rd_data),
        .req_tag(cpu_tag), .hit(hit), .hit_way(hit_way), .hit_data(hit_data)
    );

    // Line and recency updates
    always_comb begin
        wr_en    = 1'b0;
        wr_set   = rd_set;
        wr_way   = 1'b0;
        wr_tag   = cpu_tag;
        wr_data  = cpu_req_wdata;
        wr_dirty = 1'b0;
        lru_en   = 1'b0;
        lru_set  = rd_set;
        lru_used = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept && hit) begin
                    lru_en   = 1'b1;
                    lru_used = hit_way;
                    if (cpu_req_write) begin
                        wr_en    = 1'b1;
                        wr_way   = hit_way;
                        wr_dirty = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    wr_en    = 1'b1;
                    wr_set   = req_set_q;
                    wr_way   = victim_q;
                    wr_tag   = req_tag_q;
                    wr_data  = fill_word;
                    wr_dirty = req_we_q;
                    lru_en   = 1'b1;
                    lru_set  = req_set_q;
                    lru_used = victim_q;
                end
            end
            ST_FL_WB: begin
                if (mem_ready) begin
                    wr_en   = 1'b1;
                    wr_set  = fl_set;
                    wr_way  = fl_way;
                    wr_tag  = rd_tag[fl_way];
                    wr_data = rd_data[fl_way];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            cpu_resp_valid <= 1'b0;
            cpu_resp_hit   <= 1'b0;
            cpu_resp_rdata <= '0;
            req_we_q       <= 1'b0;
            req_set_q      <= '0;
            req_tag_q      <= '0;
            req_wdata_q    <= '0;
            victim_q       <= 1'b0;
            fl_idx_q       <= '0;
        end else begin
            cpu_resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (flush_start) begin
                        fl_idx_q <= '0;
                        state_q  <= ST_FL_SCAN;
                    end else if (accept) begin
                        if (hit) begin
                            cpu_resp_valid <= 1'b1;
                            cpu_resp_hit   <= 1'b1;
                            cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata : hit_data;
                        end else begin
                            req_we_q    <= cpu_req_write;
                            req_set_q   <= cpu_set;
                            req_tag_q   <= cpu_tag;
                            req_wdata_q <= cpu_req_wdata;
                            victim_q    <= rd_lru;
                            state_q     <= line_needs_wb(rd_valid[rd_lru], rd_dirty[rd_lru])
                                           ? ST_WBACK : ST_FILL;
                        end
                    end
                end
                ST_WBACK: if (mem_ready) state_q <= ST_FILL;
                ST_FILL: begin
                    if (mem_ready) begin
                        cpu_resp_valid <= 1'b1;
                        cpu_resp_hit   <= 1'b0;
                        cpu_resp_rdata <= fill_word;
                        state_q        <= ST_IDLE;
                    end
                end
                ST_FL_SCAN: begin
                    if (line_needs_wb(rd_valid[fl_way], rd_dirty[fl_way]))
                        state_q <= ST_FL_WB;
                    else if (fl_last)
                        state_q <= ST_IDLE;
                    else
                        fl_idx_q <= fl_idx_q + LINE_W'(1);
                end
                ST_FL_WB: begin
                    if (mem_ready) begin
                        if (fl_last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            fl_idx_q <= fl_idx_q + LINE_W'(1);
                            state_q  <= ST_FL_SCAN;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_req_valid,
    input logic               cpu_req_ready,
    input logic               cpu_resp_valid,
    input logic               cpu_resp_hit,
    input logic               flush_busy,
    input logic               mem_valid,
    input logic               mem_we,
    input logic [WADDR_W-1:0] mem_addr,
    input logic               mem_ready
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_STALL_ON_MEM: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !cpu_req_ready); // R9

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (cpu_resp_valid && cpu_resp_hit) |-> !mem_valid); // R3

    AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> ($past(cpu_req_valid && cpu_req_ready) || $past(mem_ready && !mem_we))); // R3

    AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_ready && mem_we && !flush_busy) |=> (mem_valid && !mem_we)); // R7

    AST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
        flush_busy |-> (!cpu_req_ready && !cpu_resp_valid)); // R10
endmodule

bind dcache_wb dcache_wb_chk #(.WADDR_W(ADDR_W - 2)) chk_i (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .flush_busy(flush_busy),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ready(mem_ready)
);

// File: tb/dcache_wb_test.sv
`timescale 1ns/1ps
module dcache_wb_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
    logic [31:0] cpu_resp_rdata;
    logic        flush_start = 1'b0, flush_busy;
    logic        mem_valid, mem_we, mem_ready;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int errors = 0, checks = 0;
    logic [31:0] mem_arr [64];
    int n_ops = 0, n_wr = 0, mcnt = 0;
    logic        log_we   [64];
    logic [29:0] log_addr [64];
    logic [31:0] log_data [64];

    always #2 clk = ~clk;

    dcache_wb uut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
        .cpu_resp_rdata(cpu_resp_rdata),
        .flush_start(flush_start), .flush_busy(flush_busy),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: fixed latency, one-cycle completion pulse
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            mcnt      <= 0;
        end else begin
            mem_ready <= 1'b0;
            if (mem_valid && !mem_ready) begin
                if (mcnt == LAT) begin
                    mcnt      <= 0;
                    mem_ready <= 1'b1;
                    log_we[n_ops % 64]   = mem_we;
                    log_addr[n_ops % 64] = mem_addr;
                    log_data[n_ops % 64] = mem_wdata;
                    n_ops = n_ops + 1;
                    if (mem_we) begin
                        mem_arr[mem_addr[5:0]] <= mem_wdata;
                        n_wr = n_wr + 1;
                    end else begin
                        mem_rdata <= mem_arr[mem_addr[5:0]];
                    end
                end else begin
                    mcnt <= mcnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic exp_hit, input logic [31:0] exp_data, input string req);
        int ops0;
        int lat;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        ops0 = n_ops;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        if (!exp_hit)
            check(cpu_req_ready == 1'b0, "R9", "ready during miss", 32'(cpu_req_ready), 32'h0);
        while (!cpu_resp_valid) begin
            @(negedge clk);
            lat++;
        end
        check(cpu_resp_hit == exp_hit, req, $sformatf("hit flag @%0h", addr),
              32'(cpu_resp_hit), 32'(exp_hit));
        check(cpu_resp_rdata == exp_data, req, $sformatf("data @%0h", addr),
              cpu_resp_rdata, exp_data);
        if (exp_hit) begin
            check(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
            check(n_ops == ops0, "R3", "memory ops on hit", 32'(n_ops - ops0), 32'd0);
        end
    endtask

    task automatic run_flush(input int exp_writes, input string req);
        int w0;
        w0 = n_wr;
        @(negedge clk);
        flush_start = 1'b1;
        @(negedge clk);
        flush_start = 1'b0;
        check(flush_busy == 1'b1, req, "flush_busy raised", 32'(flush_busy), 32'h1);
        while (flush_busy) @(negedge clk);
        check(n_wr - w0 == exp_writes, req, "flush write count", 32'(n_wr - w0), 32'(exp_writes));
    endtask

    task automatic t_reset;
        check(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 32'h1);
        check(cpu_resp_valid == 1'b0, "R1", "resp after reset", 32'(cpu_resp_valid), 32'h0);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", 32'(mem_valid), 32'h0);
        check(flush_busy == 1'b0, "R1", "flush_busy after reset", 32'(flush_busy), 32'h0);
    endtask

    task automatic t_trace;
        access(1'b0, 32'd0,  '0, 1'b0, 32'hA000_0000, "R1");
        access(1'b0, 32'd32, '0, 1'b0, 32'hA000_0008, "R8");
        access(1'b0, 32'd0,  '0, 1'b1, 32'hA000_0000, "R8");
        access(1'b0, 32'd24, '0, 1'b0, 32'hA000_0006, "R8");
        access(1'b0, 32'd32, '0, 1'b1, 32'hA000_0008, "R8");
        access(1'b0, 32'd64, '0, 1'b0, 32'hA000_0010, "R8");
    endtask

    task automatic t_lru;
        // set 0: way0=64, way1=32, way0 most recent -> 32 would be next victim
        access(1'b0, 32'd32, '0, 1'b1, 32'hA000_0008, "R6");
        access(1'b0, 32'd0,  '0, 1'b0, 32'hA000_0000, "R6");
        access(1'b0, 32'd32, '0, 1'b1, 32'hA000_0008, "R6");
        access(1'b0, 32'd64, '0, 1'b0, 32'hA000_0010, "R6");
        check(n_wr == 0, "R7", "writes for clean victims", 32'(n_wr), 32'd0);
    endtask

    task automatic t_offset;
        access(1'b0, 32'd35, '0, 1'b1, 32'hA000_0008, "R2");
        access(1'b0, 32'd4,  '0, 1'b0, 32'hA000_0001, "R2");
        access(1'b0, 32'd6,  '0, 1'b1, 32'hA000_0001, "R2");
    endtask

    task automatic t_write_hit;
        int w0;
        w0 = n_wr;
        access(1'b1, 32'd32, 32'h1111_2222, 1'b1, 32'h1111_2222, "R4");
        check(n_wr == w0, "R4", "memory writes on store hit", 32'(n_wr - w0), 32'd0);
        check(mem_arr[8] == 32'hA000_0008, "R4", "memory word 8 unchanged", mem_arr[8], 32'hA000_0008);
        access(1'b0, 32'd33, '0, 1'b1, 32'h1111_2222, "R4");
    endtask

    task automatic t_evict_dirty;
        int i0;
        access(1'b0, 32'd0, '0, 1'b0, 32'hA000_0000, "R6");
        i0 = n_ops;
        access(1'b0, 32'd96, '0, 1'b0, 32'hA000_0018, "R7");
        check(n_ops - i0 == 2, "R7", "ops for dirty miss", 32'(n_ops - i0), 32'd2);
        check(log_we[i0 % 64] == 1'b1, "R7", "first op is write", 32'(log_we[i0 % 64]), 32'h1);
        check(log_addr[i0 % 64] == 30'd8, "R7", "write-back address", 32'(log_addr[i0 % 64]), 32'd8);
        check(log_data[i0 % 64] == 32'h1111_2222, "R7", "write-back data", log_data[i0 % 64], 32'h1111_2222);
        check(log_we[(i0 + 1) % 64] == 1'b0, "R7", "second op is read", 32'(log_we[(i0 + 1) % 64]), 32'h0);
        check(log_addr[(i0 + 1) % 64] == 30'd24, "R7", "fill address", 32'(log_addr[(i0 + 1) % 64]), 32'd24);
        check(mem_arr[8] == 32'h1111_2222, "R4", "memory updated on eviction", mem_arr[8], 32'h1111_2222);
    endtask

    task automatic t_write_miss;
        int i0;
        i0 = n_ops;
        access(1'b1, 32'd128, 32'h5555_6666, 1'b0, 32'h5555_6666, "R5");
        check(n_ops - i0 == 1, "R5", "single fill for clean victim", 32'(n_ops - i0), 32'd1);
        check(log_we[i0 % 64] == 1'b0, "R5", "fill is a read", 32'(log_we[i0 % 64]), 32'h0);
        check(mem_arr[32] == 32'hA000_0020, "R5", "memory word 32 unchanged", mem_arr[32], 32'hA000_0020);
        access(1'b0, 32'd128, '0, 1'b1, 32'h5555_6666, "R5");
    endtask

    task automatic t_flush;
        int i0;
        access(1'b1, 32'd24, 32'h7777_8888, 1'b1, 32'h7777_8888, "R4");
        i0 = n_ops;
        run_flush(2, "R10");
        check(log_addr[i0 % 64] == 30'd32, "R10", "first flushed line", 32'(log_addr[i0 % 64]), 32'd32);
        check(log_addr[(i0 + 1) % 64] == 30'd6, "R10", "second flushed line", 32'(log_addr[(i0 + 1) % 64]), 32'd6);
        check(mem_arr[32] == 32'h5555_6666, "R10", "memory word 32", mem_arr[32], 32'h5555_6666);
        check(mem_arr[6] == 32'h7777_8888, "R10", "memory word 6", mem_arr[6], 32'h7777_8888);
        run_flush(0, "R10");
        access(1'b0, 32'd131, '0, 1'b1, 32'h5555_6666, "R10");
        access(1'b0, 32'd24,  '0, 1'b1, 32'h7777_8888, "R10");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem_arr[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trace();
        t_lru();
        t_offset();
        t_write_hit();
        t_evict_dirty();
        t_write_miss();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule